// File: doc/BRIEF.md
# Predicated Issue and Privilege Gate

This block sits beside the control sequencer of a small 16-bit processor and decides, for the instruction held in the instruction register, whether it may take effect. Every instruction carries a two-bit condition mask, one bit aimed at the zero flag and one at the negative flag of the status word. A set mask bit demands that the matching flag also be set. A clear mask leaves the instruction unconditional. Once the instruction passes that test, the gate checks privilege. The two highest opcodes run only in privileged mode, and issuing either of them from user mode raises a program-check flag in place of the execute enable.

The block also owns the status-word register. When the datapath presents a result with its valid strobe high, the gate rewrites the zero and negative flags from that result. It does so only for a three-operand instruction that executes and has its set-codes bit high. In every other cycle the register takes the incoming status word as it stands. Status bits other than the two flags always pass through untouched. The enable and the violation flag are combinational. The status word is registered, so an update is visible one clock after the strobe.

Top module: `cond_exec_gate`

## Requirements
- R1: A synchronous active-low reset loads `psw_o` with 16'h0004, which has only the privilege bit set. Status bit positions: Z is bit 0, N is bit 1, P is bit 2.
- R2: With both condition bits 0, `exec_en_o` is 1 for any Z and N value, provided no violation is raised.
- R3: With only `cond_z_i` set, the instruction executes only if `psw_i` bit 0 is 1. With only `cond_n_i` set, it executes only if `psw_i` bit 1 is 1.
- R4: With both condition bits set, the instruction executes only when `psw_i` bits 0 and 1 are both 1.
- R5: Opcodes 0 to 13 never raise `prog_check_o`.
- R6: Opcode 14 or 15 with a passing condition and `psw_i` bit 2 at 0 drives `prog_check_o` to 1 and `exec_en_o` to 0.
- R7: Opcode 14 or 15 with `psw_i` bit 2 at 1 and a passing condition executes without a violation.
- R8: A failing condition test gives `exec_en_o` = 0 and `prog_check_o` = 0, and the next `psw_o` equals `psw_i`.
- R9: For an executing three-operand opcode (0, 2, 4, 5, 6 or 7) with `set_cc_i` = 1 and `result_valid_i` = 1, the next `psw_o` has bit 0 = (result == 0), bit 1 = result bit 15, and all other bits taken from `psw_i`.
- R10: With `set_cc_i` = 0, or with an opcode that is not three-operand, the next `psw_o` equals `psw_i`.
- R11: In a cycle that raises a violation, the next `psw_o` equals `psw_i`.
- R12: With `result_valid_i` = 0, the next `psw_o` equals `psw_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_z_i | input | 1 | Condition mask bit that requires Z |
| cond_n_i | input | 1 | Condition mask bit that requires N |
| opcode_i | input | 4 | Instruction opcode |
| set_cc_i | input | 1 | Instruction requests a condition-code update |
| psw_i | input | 16 | Current status word |
| result_valid_i | input | 1 | Result value is valid this cycle |
| result_i | input | 16 | Result value from the datapath |
| exec_en_o | output | 1 | Instruction may take effect |
| prog_check_o | output | 1 | Privileged opcode issued from user mode |
| psw_o | output | 16 | Registered, updated status word |

## Verification
The bench targets several corner cases. The both-bits-set mask with only one flag present would pass in a design that ORs the mask bits instead of ANDing them. A privileged opcode whose condition fails must raise no violation, and a design that checks privilege before the predicate would report a false trap. A zero result from a violating or two-operand instruction must leave the flags alone, so a design that decodes only the set-codes bit would wrongly set Z. An update whose status word has every unrelated bit set shows whether the gate writes back only the two flags or clobbers the rest.

// File: rtl/cxg_pkg.sv
// Package for the predicated issue gate.
// What it does: holds the shared flag-pair type and the mask-match helper.
// Assumes: the condition mask is always the pair {Z, N}.
package cxg_pkg;

    // Pair of condition flags, in the same order as the instruction mask.
    typedef struct packed {
        logic z;
        logic n;
    } cc_pair_t;

    // True when every flag demanded by the mask is present.
    function automatic logic mask_met(input cc_pair_t need, input cc_pair_t have);
        return ((need.z & ~have.z) | (need.n & ~have.n)) == 1'b0;
    endfunction

endpackage

// File: rtl/cxg_cond_eval.sv
// Condition evaluator.
// What it does: compares the instruction's two-bit mask against the Z and N
// flags of the current status word and reports whether the test passes.
// Assumes: a clear mask bit imposes no requirement on its flag.
module cxg_cond_eval
    import cxg_pkg::*;
(
    input  logic cond_z_i,
    input  logic cond_n_i,
    input  logic flag_z_i,
    input  logic flag_n_i,
    output logic pass_o
);

    cc_pair_t need;
    cc_pair_t have;

    // Pack the mask and the flags, then test that the mask is covered.
    always_comb begin
        need.z = cond_z_i;
        need.n = cond_n_i;
        have.z = flag_z_i;
        have.n = flag_n_i;
        pass_o = mask_met(need, have);
    end

endmodule

// File: rtl/cxg_priv_check.sv
// Privilege checker.
// What it does: decodes privileged opcodes from a parameter mask and turns
// a passing instruction into either an execute enable or a program check.
// Assumes: the privilege test only applies after the condition test passes.
module cxg_priv_check #(
    parameter int                 OPC_W     = 4,
    parameter int                 N_OPS     = 1 << OPC_W,
    parameter logic [N_OPS-1:0]   PRIV_MASK = '0
) (
    input  logic             cond_pass_i,
    input  logic             priv_mode_i,
    input  logic [OPC_W-1:0] opcode_i,
    output logic             exec_o,
    output logic             viol_o
);

    logic [N_OPS-1:0] hit;
    logic             is_priv;

    // One comparator per opcode that the mask marks as privileged.
    for (genvar k = 0; k < N_OPS; k++) begin : g_dec
        if (PRIV_MASK[k]) begin : g_on
            assign hit[k] = (opcode_i == OPC_W'(k));
        end else begin : g_off
            assign hit[k] = 1'b0;
        end
    end

    // Resolve trap versus execute for a passing instruction.
    always_comb begin
        is_priv = |hit;
        viol_o  = cond_pass_i & is_priv & ~priv_mode_i;
        exec_o  = cond_pass_i & ~(is_priv & ~priv_mode_i);
    end

endmodule

// File: rtl/cxg_cc_update.sv
// Status-word register with condition-code writer.
// What it does: captures the incoming status word each cycle and replaces
// the Z and N flags from the result when a flag-setting three-operand
// instruction executes with a valid result.
// Assumes: psw_i is the authoritative status word whenever no update fires.
module cxg_cc_update #(
    parameter int                  DATA_W    = 16,
    parameter int                  OPC_W     = 4,
    parameter int                  N_OPS     = 1 << OPC_W,
    parameter logic [N_OPS-1:0]    TRI_MASK  = '0,
    parameter int                  Z_BIT     = 0,
    parameter int                  N_BIT     = 1,
    parameter logic [DATA_W-1:0]   RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              set_cc_i,
    input  logic              exec_i,
    input  logic              result_valid_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic [DATA_W-1:0] psw_i,
    output logic [DATA_W-1:0] psw_o
);

    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << Z_BIT) | (DATA_W'(1) << N_BIT);

    logic [N_OPS-1:0]  tri_hit;
    logic              is_tri;
    logic              do_write;
    logic              res_zero;
    logic              res_neg;
    logic [DATA_W-1:0] next_psw;

    // One comparator per opcode of the three-operand format.
    for (genvar k = 0; k < N_OPS; k++) begin : g_tri
        if (TRI_MASK[k]) begin : g_on
            assign tri_hit[k] = (opcode_i == OPC_W'(k));
        end else begin : g_off
            assign tri_hit[k] = 1'b0;
        end
    end

    // Decide whether the flags are written and form the next status word.
    always_comb begin
        is_tri          = |tri_hit;
        do_write        = is_tri & set_cc_i & exec_i & result_valid_i;
        res_zero        = (result_i == '0);
        res_neg         = result_i[DATA_W-1];
        next_psw        = psw_i;
        if (do_write) begin
            next_psw[Z_BIT] = res_zero;
            next_psw[N_BIT] = res_neg;
        end
    end

    // Status-word register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) psw_o <= RESET_VAL;
        else        psw_o <= next_psw;
    end

    // A write takes Z from the zero test of the result (R9).
    p_z_from_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && set_cc_i && result_valid_i && TRI_MASK[opcode_i])
        |=> psw_o[Z_BIT] == ($past(result_i) == '0));

    // A write takes N from the sign of the result (R9).
    p_n_from_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && set_cc_i && result_valid_i && TRI_MASK[opcode_i])
        |=> psw_o[N_BIT] == $past(result_i[DATA_W-1]));

    // Bits outside the flag pair always follow the incoming word (R9).
    p_other_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((psw_o ^ $past(psw_i)) & ~FLAG_MASK) == '0);

    // Without a set-codes request the whole word passes through (R10).
    p_no_set_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !set_cc_i |=> psw_o == $past(psw_i));

    // Without a valid result the whole word passes through (R12).
    p_no_valid_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_i |=> psw_o == $past(psw_i));

endmodule

// File: rtl/cond_exec_gate.sv
// Predicated issue and privilege gate (top).
// What it does: evaluates the instruction's Z/N condition mask, traps the
// privileged opcodes in user mode, and keeps the status-word register with
// its condition-code updates.
// Assumes: one instruction is presented at a time and psw_i reflects the
// live status word; exception sequencing is handled elsewhere.
module cond_exec_gate #(
    parameter int                DATA_W    = 16,
    parameter int                OPC_W     = 4,
    parameter int                Z_BIT     = 0,
    parameter int                N_BIT     = 1,
    parameter int                P_BIT     = 2,
    parameter logic [15:0]       PRIV_OPS  = 16'hC000,
    parameter logic [15:0]       TRI_OPS   = 16'h00F5,
    parameter logic [DATA_W-1:0] RESET_PSW = DATA_W'(16'h0004)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond_z_i,
    input  logic              cond_n_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              set_cc_i,
    input  logic [DATA_W-1:0] psw_i,
    input  logic              result_valid_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              exec_en_o,
    output logic              prog_check_o,
    output logic [DATA_W-1:0] psw_o
);

    localparam int                N_OPS     = 1 << OPC_W;
    localparam logic [N_OPS-1:0]  PRIV_MASK = N_OPS'(PRIV_OPS);
    localparam logic [N_OPS-1:0]  TRI_MASK  = N_OPS'(TRI_OPS);

    logic cond_pass;

    cxg_cond_eval u_cond (
        .cond_z_i (cond_z_i),
        .cond_n_i (cond_n_i),
        .flag_z_i (psw_i[Z_BIT]),
        .flag_n_i (psw_i[N_BIT]),
        .pass_o   (cond_pass)
    );

    cxg_priv_check #(
        .OPC_W     (OPC_W),
        .N_OPS     (N_OPS),
        .PRIV_MASK (PRIV_MASK)
    ) u_priv (
        .cond_pass_i (cond_pass),
        .priv_mode_i (psw_i[P_BIT]),
        .opcode_i    (opcode_i),
        .exec_o      (exec_en_o),
        .viol_o      (prog_check_o)
    );

    cxg_cc_update #(
        .DATA_W    (DATA_W),
        .OPC_W     (OPC_W),
        .N_OPS     (N_OPS),
        .TRI_MASK  (TRI_MASK),
        .Z_BIT     (Z_BIT),
        .N_BIT     (N_BIT),
        .RESET_VAL (RESET_PSW)
    ) u_cc (
        .clk            (clk),
        .rst_n          (rst_n),
        .opcode_i       (opcode_i),
        .set_cc_i       (set_cc_i),
        .exec_i         (exec_en_o),
        .result_valid_i (result_valid_i),
        .result_i       (result_i),
        .psw_i          (psw_i),
        .psw_o          (psw_o)
    );

    // An unconditional, non-trapping instruction always executes (R2).
    p_uncond_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond_z_i && !cond_n_i && !prog_check_o) |-> exec_en_o);

    // A demanded Z that is absent blocks execution (R3).
    p_z_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_z_i && !psw_i[Z_BIT]) |-> !exec_en_o);

    // A demanded N that is absent blocks execution (R3).
    p_n_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_n_i && !psw_i[N_BIT]) |-> !exec_en_o);

    // Unprivileged opcodes never trap (R5).
    p_user_ops_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !PRIV_MASK[opcode_i] |-> !prog_check_o);

    // A trap always withholds the execute enable (R6).
    p_trap_blocks_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_check_o |-> !exec_en_o);

    // Privileged mode never traps (R7).
    p_priv_mode_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        psw_i[P_BIT] |-> !prog_check_o);

    // A failed condition neither executes nor traps (R8).
    p_fail_is_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_z_i && !psw_i[Z_BIT]) || (cond_n_i && !psw_i[N_BIT]))
        |-> (!exec_en_o && !prog_check_o));

    // A trapping cycle leaves the status word as presented (R11).
    p_trap_no_update_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_check_o |=> psw_o == $past(psw_i));

endmodule

// File: tb/tb_cond_exec_gate.sv
module tb_cond_exec_gate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cond_z_i, cond_n_i, set_cc_i, result_valid_i;
    logic [3:0]  opcode_i;
    logic [15:0] psw_i, result_i;
    logic        exec_en_o, prog_check_o;
    logic [15:0] psw_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cond_exec_gate dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cond_z_i       (cond_z_i),
        .cond_n_i       (cond_n_i),
        .opcode_i       (opcode_i),
        .set_cc_i       (set_cc_i),
        .psw_i          (psw_i),
        .result_valid_i (result_valid_i),
        .result_i       (result_i),
        .exec_en_o      (exec_en_o),
        .prog_check_o   (prog_check_o),
        .psw_o          (psw_o)
    );

    typedef struct packed {
        logic        cz;
        logic        cn;
        logic [3:0]  op;
        logic        s;
        logic [15:0] psw;
        logic        rv;
        logic [15:0] res;
        logic        x_exec;
        logic        x_viol;
        logic [15:0] x_psw;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,4'd0, 1'b1,16'h0004,1'b1,16'h0000,1'b1,1'b0,16'h0005,8'd2},
        '{1'b0,1'b0,4'd0, 1'b1,16'h0000,1'b1,16'h8000,1'b1,1'b0,16'h0002,8'd9},
        '{1'b1,1'b0,4'd2, 1'b1,16'h0000,1'b1,16'h0000,1'b0,1'b0,16'h0000,8'd8},
        '{1'b1,1'b0,4'd2, 1'b1,16'h0001,1'b1,16'h0005,1'b1,1'b0,16'h0000,8'd3},
        '{1'b0,1'b1,4'd4, 1'b1,16'h0002,1'b1,16'hFFFF,1'b1,1'b0,16'h0002,8'd3},
        '{1'b0,1'b1,4'd4, 1'b1,16'h0001,1'b1,16'h0000,1'b0,1'b0,16'h0001,8'd8},
        '{1'b1,1'b1,4'd5, 1'b1,16'h0001,1'b1,16'h0000,1'b0,1'b0,16'h0001,8'd4},
        '{1'b1,1'b1,4'd5, 1'b1,16'h0003,1'b1,16'h0000,1'b1,1'b0,16'h0001,8'd4},
        '{1'b0,1'b0,4'd14,1'b1,16'h0000,1'b1,16'h0000,1'b0,1'b1,16'h0000,8'd6},
        '{1'b0,1'b0,4'd15,1'b1,16'hF0F0,1'b1,16'h0000,1'b0,1'b1,16'hF0F0,8'd11},
        '{1'b0,1'b0,4'd15,1'b1,16'h0004,1'b1,16'h0000,1'b1,1'b0,16'h0004,8'd7},
        '{1'b1,1'b0,4'd14,1'b1,16'h0000,1'b1,16'h0000,1'b0,1'b0,16'h0000,8'd8},
        '{1'b0,1'b0,4'd1, 1'b1,16'h0000,1'b1,16'h0000,1'b1,1'b0,16'h0000,8'd10},
        '{1'b0,1'b0,4'd0, 1'b0,16'h0008,1'b1,16'h0000,1'b1,1'b0,16'h0008,8'd10},
        '{1'b0,1'b0,4'd7, 1'b1,16'h0000,1'b0,16'h0000,1'b1,1'b0,16'h0000,8'd12},
        '{1'b0,1'b0,4'd6, 1'b1,16'hFFF3,1'b1,16'h1234,1'b1,1'b0,16'hFFF0,8'd9},
        '{1'b0,1'b0,4'd13,1'b1,16'h0000,1'b1,16'h0000,1'b1,1'b0,16'h0000,8'd5}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check combinational outputs, then psw after the rising edge.
    task automatic apply(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        cond_z_i = v.cz; cond_n_i = v.cn; opcode_i = v.op; set_cc_i = v.s;
        psw_i = v.psw; result_valid_i = v.rv; result_i = v.res;
        #2;
        check(tag, "exec_en", 16'(exec_en_o), 16'(v.x_exec));
        check(tag, "prog_check", 16'(prog_check_o), 16'(v.x_viol));
        @(negedge clk);
        check(tag, "psw", psw_o, v.x_psw);
    endtask

    initial begin
        rst_n = 1'b0;
        cond_z_i = 1'b0; cond_n_i = 1'b0; opcode_i = 4'd0; set_cc_i = 1'b0;
        psw_i = 16'h0000; result_valid_i = 1'b0; result_i = 16'h0000;
        repeat (3) @(negedge clk);
        check("R1", "reset psw", psw_o, 16'h0004);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R5 R6: every opcode in user mode with no condition.
        for (int op = 0; op < 16; op++) begin
            vec_t v;
            v = '{1'b0,1'b0,4'(op),1'b0,16'h0000,1'b0,16'h0000,
                  (op < 14) ? 1'b1 : 1'b0, (op >= 14) ? 1'b1 : 1'b0,
                  16'h0000, (op < 14) ? 8'd5 : 8'd6};
            apply(v);
        end

        // R7: every opcode in privileged mode executes without trapping.
        for (int op = 0; op < 16; op++) begin
            vec_t v;
            v = '{1'b0,1'b0,4'(op),1'b0,16'h0004,1'b0,16'h0000,1'b1,1'b0,16'h0004,8'd7};
            apply(v);
        end

        // R4: both mask bits with only N present must not execute.
        apply('{1'b1,1'b1,4'd0,1'b1,16'h0002,1'b1,16'h0000,1'b0,1'b0,16'h0002,8'd4});
        // R9: negative non-zero result in privileged mode, P preserved.
        apply('{1'b0,1'b0,4'd2,1'b1,16'h0005,1'b1,16'h8001,1'b1,1'b0,16'h0006,8'd9});

        // R1: reset mid-run returns psw to its reset value.
        @(negedge clk);
        psw_i = 16'hFFFF; rst_n = 1'b0;
        @(negedge clk);
        check("R1", "mid-run reset psw", psw_o, 16'h0004);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule